// File: doc/BRIEF.md
# Partitioned Multi-Endpoint Transmit FIFO Bank

This block holds one transmit queue per IN endpoint of a USB-style peripheral. All of the queues live in a single shared data RAM. Because each endpoint has its own queue, the peripheral never has to guess which endpoint the host will poll next. Software places each queue inside the RAM at run time with one configuration word per endpoint. The low region of the RAM, starting at word 0, is kept for receive traffic. Software therefore places the transmit queues above it.

The bus side pushes 32-bit words. The push address selects the endpoint: every endpoint owns an address window, and any address inside that window reaches the same queue. The link side drains one endpoint at a time while that endpoint is being serviced. The popped word appears one cycle after the request.

Each queue reports its free space in words. Software can read it to make sure there is room before writing a packet. Each queue also drives one bit of an empty-level interrupt vector. A shared level select decides whether that bit means "at least half empty" or "completely empty". Pushes into a full queue are discarded and recorded in a sticky overflow flag. A per-endpoint flush resets one queue and leaves the others untouched.

Top module: `ep_txfifo_bank`

## Requirements
- R1: Configuration word n (cfg_i[32n+31:32n]) gives the depth of queue n in bits [31:16] and its start word address in bits [15:0]. A depth larger than the RAM is clamped to the RAM size. After reset every queue is empty, free_words_o shows the full depth, overflow_o is 0 and pop_ok_o is 0.
- R2: A push goes to the endpoint given by push_addr_i[11:10]. The low ten address bits have no effect on which queue receives the word or on where it is stored.
- R3: Each queue returns its words in push order. Its read and write positions wrap within [start, start+depth-1] and never leave that range. Traffic on one queue never changes the data of another.
- R4: free_words_o[16n+15:16n] equals the depth of queue n minus the number of words it holds. It is updated in the cycle after each push or pop.
- R5: A push to a full queue is discarded and sets overflow_o[n]. That flag stays set until queue n is flushed.
- R6: A pop from an empty queue moves no pointer. In the next cycle it shows pop_ok_o = 0 and pop_data_o = 0.
- R7: A pop from a non-empty queue gives pop_ok_o = 1 and the oldest word on pop_data_o in the cycle after pop_valid_i.
- R8: With level_sel_i = 1, empty_irq_o[n] is 1 while 2*free >= depth. With level_sel_i = 0, it is 1 only while free equals depth. A queue of depth 0 never raises it.
- R9: flush_i[n] empties queue n and clears overflow_o[n]. A push or pop to queue n in the same cycle is ignored, and the push does not set overflow. Other queues are unaffected.
- R10: A push and a pop to the same queue in one cycle both take effect. Full and empty are judged on the state before that cycle, so a full queue drops the push while still serving the pop, and an empty queue misses the pop while still taking the push.
- R11: A queue of depth 0 shows free space 0 and drops every push, setting its overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | NUM_EP*32 | Per-endpoint depth and start word address |
| level_sel_i | input | 1 | 1: half-empty interrupt level, 0: fully-empty level |
| flush_i | input | NUM_EP | Per-endpoint queue flush |
| push_valid_i | input | 1 | Push strobe |
| push_addr_i | input | EP_W+PUSH_WIN_LOG2 | Push address; upper bits select the endpoint |
| push_data_i | input | DATA_W | Word to push |
| pop_valid_i | input | 1 | Pop strobe from the link side |
| pop_ep_i | input | EP_W | Endpoint being serviced |
| pop_ok_o | output | 1 | Previous-cycle pop returned a word |
| pop_data_o | output | DATA_W | Popped word, 0 when pop_ok_o is 0 |
| free_words_o | output | NUM_EP*16 | Free space per queue in words |
| empty_irq_o | output | NUM_EP | Empty-level interrupt per queue |
| overflow_o | output | NUM_EP | Sticky overflow flag per queue |

## Verification
The bus push and the link pop can land on the same queue in the same cycle. That overlap is where the pre-cycle full and empty judgement matters. The bench drives both strobes together on a partly filled queue, on a full queue and on an empty queue. It compares the popped word, the new free count and the overflow flag against a bench model that updates from the state before the edge. A flush that coincides with a push and a pop to the same queue is provoked as well, and it is judged by the queue coming out empty with its overflow flag clear.

// File: rtl/txfb_pkg.sv
package txfb_pkg;

  localparam int CFG_W   = 32;
  localparam int FIELD_W = 16;

  typedef logic [FIELD_W-1:0] field_t;

  // Depth field of a configuration word, limited to the RAM size.
  function automatic field_t clamp_depth(input logic [CFG_W-1:0] cfg, input int unsigned lim);
    field_t raw;
    raw = cfg[31:16];
    if (32'(raw) > lim) return field_t'(lim);
    return raw;
  endfunction

  function automatic field_t start_of(input logic [CFG_W-1:0] cfg);
    return cfg[15:0];
  endfunction

  // Advance an offset inside a partition of the given depth.
  function automatic field_t wrap_inc(input field_t off, input field_t depth);
    if (32'(off) + 1 >= 32'(depth)) return '0;
    return off + 16'd1;
  endfunction

  // Physical word address of an offset within a partition.
  function automatic field_t part_addr(input field_t start, input field_t off);
    return start + off;
  endfunction

  function automatic field_t free_space(input field_t depth, input field_t fill);
    if (fill >= depth) return '0;
    return depth - fill;
  endfunction

  function automatic logic irq_level(input field_t free, input field_t depth, input logic half);
    if (depth == '0) return 1'b0;
    if (half) return ({free, 1'b0} >= {1'b0, depth});
    return (free == depth);
  endfunction

endpackage

// File: rtl/txfb_push_decode.sv
module txfb_push_decode #(
  parameter int NUM_EP        = 4,
  parameter int PUSH_WIN_LOG2 = 10,
  localparam int EP_W         = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int PA_W         = EP_W + PUSH_WIN_LOG2
) (
  input  logic              valid_i,
  input  logic [PA_W-1:0]   addr_i,
  output logic [EP_W-1:0]   ep_o,
  output logic [NUM_EP-1:0] hit_o
);
  assign ep_o = addr_i[PA_W-1:PUSH_WIN_LOG2];

  for (genvar g = 0; g < NUM_EP; g++) begin : g_hit
    assign hit_o[g] = valid_i && (ep_o == EP_W'(g));
  end
endmodule

// File: rtl/txfb_part_ctrl.sv
module txfb_part_ctrl
  import txfb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  field_t        start_i,
  input  field_t        depth_i,
  input  logic          push_hit_i,
  input  logic          pop_hit_i,
  input  logic          flush_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          push_accept_o,
  output logic          push_drop_o,
  output logic          pop_accept_o,
  output logic          pop_miss_o,
  output field_t        fill_o,
  output logic          overflow_o
);
  field_t wr_off_q, rd_off_q, fill_q;
  logic   ovf_q;
  logic   full, empty;
  field_t wa, ra;

  assign full  = (fill_q >= depth_i);
  assign empty = (fill_q == '0);

  assign push_accept_o = push_hit_i && !flush_i && !full;
  assign push_drop_o   = push_hit_i && !flush_i && full;
  assign pop_accept_o  = pop_hit_i && !flush_i && !empty;
  assign pop_miss_o    = pop_hit_i && !flush_i && empty;

  assign wa        = part_addr(start_i, wr_off_q);
  assign ra        = part_addr(start_i, rd_off_q);
  assign wr_addr_o = wa[AW-1:0];
  assign rd_addr_o = ra[AW-1:0];
  assign fill_o    = fill_q;
  assign overflow_o = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off_q <= '0;
      rd_off_q <= '0;
      fill_q   <= '0;
      ovf_q    <= 1'b0;
    end else if (flush_i) begin
      wr_off_q <= '0;
      rd_off_q <= '0;
      fill_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_accept_o) wr_off_q <= wrap_inc(wr_off_q, depth_i);
      if (pop_accept_o)  rd_off_q <= wrap_inc(rd_off_q, depth_i);
      case ({push_accept_o, pop_accept_o})
        2'b10:   fill_q <= fill_q + 16'd1;
        2'b01:   fill_q <= fill_q - 16'd1;
        default: fill_q <= fill_q;
      endcase
      if (push_drop_o) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/txfb_ram.sv
module txfb_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/ep_txfifo_bank.sv
module ep_txfifo_bank
  import txfb_pkg::*;
#(
  parameter int NUM_EP        = 4,
  parameter int RAM_DEPTH     = 64,
  parameter int DATA_W        = 32,
  parameter int PUSH_WIN_LOG2 = 10,
  localparam int EP_W         = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int PA_W         = EP_W + PUSH_WIN_LOG2,
  localparam int AW           = $clog2(RAM_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_EP*CFG_W-1:0] cfg_i,
  input  logic                    level_sel_i,
  input  logic [NUM_EP-1:0]       flush_i,
  input  logic                    push_valid_i,
  input  logic [PA_W-1:0]         push_addr_i,
  input  logic [DATA_W-1:0]       push_data_i,
  input  logic                    pop_valid_i,
  input  logic [EP_W-1:0]         pop_ep_i,
  output logic                    pop_ok_o,
  output logic [DATA_W-1:0]       pop_data_o,
  output logic [NUM_EP*16-1:0]    free_words_o,
  output logic [NUM_EP-1:0]       empty_irq_o,
  output logic [NUM_EP-1:0]       overflow_o
);
  // Internal events, named for the checker.
  logic [NUM_EP-1:0]    push_hit, pop_hit;
  logic [NUM_EP-1:0]    push_accept, push_drop, pop_accept, pop_miss;
  logic [NUM_EP*16-1:0] depth_eff;
  logic [EP_W-1:0]      push_ep;

  logic [AW-1:0] wr_addr [NUM_EP];
  logic [AW-1:0] rd_addr [NUM_EP];

  txfb_push_decode #(.NUM_EP(NUM_EP), .PUSH_WIN_LOG2(PUSH_WIN_LOG2)) u_dec (
    .valid_i (push_valid_i),
    .addr_i  (push_addr_i),
    .ep_o    (push_ep),
    .hit_o   (push_hit)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_part
    field_t start_w, depth_w, fill_w, free_w;

    assign start_w = start_of(cfg_i[g*CFG_W +: CFG_W]);
    assign depth_w = clamp_depth(cfg_i[g*CFG_W +: CFG_W], RAM_DEPTH);
    assign pop_hit[g] = pop_valid_i && (pop_ep_i == EP_W'(g));

    txfb_part_ctrl #(.AW(AW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_w),
      .depth_i      (depth_w),
      .push_hit_i   (push_hit[g]),
      .pop_hit_i    (pop_hit[g]),
      .flush_i      (flush_i[g]),
      .wr_addr_o    (wr_addr[g]),
      .rd_addr_o    (rd_addr[g]),
      .push_accept_o(push_accept[g]),
      .push_drop_o  (push_drop[g]),
      .pop_accept_o (pop_accept[g]),
      .pop_miss_o   (pop_miss[g]),
      .fill_o       (fill_w),
      .overflow_o   (overflow_o[g])
    );

    assign free_w                = free_space(depth_w, fill_w);
    assign free_words_o[g*16 +: 16] = free_w;
    assign depth_eff[g*16 +: 16] = depth_w;
    assign empty_irq_o[g]        = irq_level(free_w, depth_w, level_sel_i);
  end

  logic [DATA_W-1:0] ram_q;
  logic              pop_ok_q;

  txfb_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (|push_accept),
    .waddr_i(wr_addr[push_ep]),
    .wdata_i(push_data_i),
    .re_i   (|pop_accept),
    .raddr_i(rd_addr[pop_ep_i]),
    .rdata_o(ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pop_ok_q <= 1'b0;
    else        pop_ok_q <= |pop_accept;
  end

  assign pop_ok_o   = pop_ok_q;
  assign pop_data_o = pop_ok_q ? ram_q : '0;
endmodule

// File: rtl/ep_txfifo_bank_chk.sv
module ep_txfifo_bank_chk #(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 level_sel_i,
  input logic [NUM_EP-1:0]    flush_i,
  input logic [NUM_EP*16-1:0] free_words_o,
  input logic [NUM_EP*16-1:0] depth_eff,
  input logic [NUM_EP-1:0]    empty_irq_o,
  input logic [NUM_EP-1:0]    overflow_o,
  input logic [NUM_EP-1:0]    push_drop,
  input logic [NUM_EP-1:0]    pop_accept,
  input logic [NUM_EP-1:0]    pop_miss,
  input logic                 pop_ok_o,
  input logic [DATA_W-1:0]    pop_data_o
);
  for (genvar g = 0; g < NUM_EP; g++) begin : g_chk
    // R4
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_words_o[g*16 +: 16] <= depth_eff[g*16 +: 16]);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o[g] && !flush_i[g] |=> overflow_o[g]);

    // R5
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_drop[g] && !pop_accept[g] && !flush_i[g] |=> $stable(free_words_o[g*16 +: 16]));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_miss[g] |=> !pop_ok_o && pop_data_o == '0);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i[g] |=> !overflow_o[g]);

    // R8
    full_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !level_sel_i && depth_eff[g*16 +: 16] != '0 &&
      free_words_o[g*16 +: 16] == depth_eff[g*16 +: 16] |-> empty_irq_o[g]);
  end
endmodule

bind ep_txfifo_bank ep_txfifo_bank_chk #(.NUM_EP(NUM_EP), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .level_sel_i (level_sel_i),
  .flush_i     (flush_i),
  .free_words_o(free_words_o),
  .depth_eff   (depth_eff),
  .empty_irq_o (empty_irq_o),
  .overflow_o  (overflow_o),
  .push_drop   (push_drop),
  .pop_accept  (pop_accept),
  .pop_miss    (pop_miss),
  .pop_ok_o    (pop_ok_o),
  .pop_data_o  (pop_data_o)
);

// File: tb/ep_txfifo_bank_test.sv
module ep_txfifo_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE*32-1:0] cfg;
  logic level_sel = 1'b0;
  logic [NE-1:0] flush = '0;
  logic push_v = 1'b0;
  logic [11:0] push_addr = '0;
  logic [31:0] push_data = '0;
  logic pop_v = 1'b0;
  logic [1:0] pop_ep = '0;
  logic pop_ok;
  logic [31:0] pop_data;
  logic [NE*16-1:0] free_w;
  logic [NE-1:0] irq, ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_txfifo_bank uut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .level_sel_i(level_sel),
    .flush_i(flush), .push_valid_i(push_v), .push_addr_i(push_addr),
    .push_data_i(push_data), .pop_valid_i(pop_v), .pop_ep_i(pop_ep),
    .pop_ok_o(pop_ok), .pop_data_o(pop_data), .free_words_o(free_w),
    .empty_irq_o(irq), .overflow_o(ovf)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Bench model
  int m_depth [NE];
  int m_cnt [NE];
  int m_head [NE];
  bit m_ovf [NE];
  logic [31:0] m_buf [NE][64];
  bit exp_ok;
  logic [31:0] exp_data;
  int seed = 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_irq(input int e);
    int fr;
    fr = m_depth[e] - m_cnt[e];
    if (m_depth[e] == 0) return 0;
    if (level_sel) return fr >= (m_depth[e] + 1) / 2;
    return fr == m_depth[e];
  endfunction

  task automatic set_cfg(input int e, input int depth, input int start);
    cfg[e*32 +: 32] = {16'(depth), 16'(start)};
    m_depth[e] = depth;
  endtask

  task automatic check_all(input bit pop_chk);
    for (int e = 0; e < NE; e++) begin
      chk(free_w[e*16 +: 16] == 16'(m_depth[e] - m_cnt[e]), $sformatf("R4 free ep%0d", e),
          free_w[e*16 +: 16], m_depth[e] - m_cnt[e]);
      chk(irq[e] == exp_irq(e), $sformatf("R8 irq ep%0d", e), irq[e], exp_irq(e));
      chk(ovf[e] == m_ovf[e], $sformatf("R5 overflow ep%0d", e), ovf[e], m_ovf[e]);
    end
    if (pop_chk) begin
      if (exp_ok) begin
        chk(pop_ok == 1'b1, "R7 pop_ok", pop_ok, 1);
        chk(pop_data == exp_data, "R3 R7 pop data", pop_data, exp_data);
      end else begin
        chk(pop_ok == 1'b0 && pop_data == 32'h0, "R6 empty pop", {pop_ok, pop_data}, 0);
      end
    end
  endtask

  // One clock with the given stimulus; the model updates from the pre-edge state.
  task automatic step(input bit pv, input int pe, input int low, input logic [31:0] d,
                      input bit qv, input int qe, input logic [NE-1:0] fl);
    int c0;
    push_v = pv; push_addr = {2'(pe), 10'(low)}; push_data = d;
    pop_v = qv; pop_ep = 2'(qe); flush = fl;
    exp_ok = 0; exp_data = '0;
    @(posedge clk);
    for (int e = 0; e < NE; e++) begin
      if (fl[e]) begin
        m_cnt[e] = 0; m_head[e] = 0; m_ovf[e] = 0;
      end else begin
        c0 = m_cnt[e];
        if (qv && qe == e && c0 > 0) begin
          exp_ok = 1; exp_data = m_buf[e][m_head[e]];
          m_head[e] = (m_head[e] + 1) % 64; m_cnt[e]--;
        end
        if (pv && pe == e) begin
          if (c0 < m_depth[e]) begin
            m_buf[e][(m_head[e] + m_cnt[e]) % 64] = d; m_cnt[e]++;
          end else m_ovf[e] = 1;
        end
      end
    end
    @(negedge clk);
    push_v = 0; pop_v = 0; flush = '0;
    check_all(qv);
  endtask

  function automatic logic [31:0] nextword();
    seed = seed * 1103515245 + 12345;
    return 32'(seed);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg = '0;
    set_cfg(0, 4, 16); set_cfg(1, 8, 20); set_cfg(2, 3, 28); set_cfg(3, 8, 56);
    for (int e = 0; e < NE; e++) begin m_cnt[e] = 0; m_head[e] = 0; m_ovf[e] = 0; end
    exp_ok = 0; exp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pop_ok == 1'b0, "R1 pop_ok after reset", pop_ok, 0);
    check_all(1'b0);

    // Fill past full then drain past empty, both interrupt levels (R2 R3 R5 R6 R7 R8)
    for (int lv = 0; lv < 2; lv++) begin
      level_sel = lv[0];
      for (int e = 0; e < NE; e++) begin
        for (int k = 0; k <= m_depth[e]; k++)
          step(1, e, (k * 97 + e * 13) % 1024, nextword(), 0, 0, '0);
        for (int k = 0; k <= m_depth[e]; k++)
          step(0, 0, 0, '0, 1, e, '0);
        // R9 flush clears overflow
        step(0, 0, 0, '0, 0, 0, 4'(1 << e));
      end
    end

    // R3 wrap inside a small partition
    level_sel = 1'b1;
    for (int r = 0; r < 10; r++) begin
      step(1, 2, r, nextword(), 0, 0, '0);
      step(1, 2, 1023 - r, nextword(), 0, 0, '0);
      step(0, 0, 0, '0, 1, 2, '0);
      step(0, 0, 0, '0, 1, 2, '0);
    end

    // R10 concurrent push and pop: partial, full, empty
    step(1, 1, 5, nextword(), 0, 0, '0);
    step(1, 1, 6, nextword(), 1, 1, '0);
    for (int k = 0; k < 7; k++) step(1, 1, k, nextword(), 0, 0, '0);
    step(1, 1, 9, nextword(), 1, 1, '0);
    for (int k = 0; k < 8; k++) step(0, 0, 0, '0, 1, 1, '0);
    step(1, 1, 3, 32'hA5A5_0001, 1, 1, '0);
    step(0, 0, 0, '0, 1, 1, '0);

    // R9 flush isolation, flush beats same-cycle push and pop
    for (int e = 0; e < NE; e++) begin
      step(1, e, 0, nextword(), 0, 0, '0);
      step(1, e, 1, nextword(), 0, 0, '0);
    end
    step(1, 1, 2, nextword(), 1, 1, 4'b0010);
    for (int e = 0; e < NE; e++)
      for (int k = 0; k < 3; k++) step(0, 0, 0, '0, 1, e, '0);

    // R11 zero-depth partition
    set_cfg(3, 0, 56);
    step(0, 0, 0, '0, 0, 0, 4'b1000);
    step(1, 3, 0, nextword(), 0, 0, '0);
    step(0, 0, 0, '0, 1, 3, '0);
    chk(ovf[3] == 1'b1, "R11 zero-depth overflow", ovf[3], 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule